// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block reads the processor's fundamental mode settings at reset time from a slow serial input. Once the power-good input is high, it drives a mode clock at a fixed fraction of the system clock. It takes one data bit on each rising edge of that clock, lowest index first, until the whole fixed-length stream has been read. A small set of positions in the stream carry settings. Those bits are kept and decoded into registered outputs. The outputs then hold steady for the rest of the design until the next power loss or cold reset.

The same block releases reset to the core in order. The cold reset it drives to the core stays asserted until the stream has been fully read and the board's cold reset has been released. The core's warm reset is released a fixed number of cycles after that. A later warm reset from the board pulls the core's warm reset low again, but it does not start a new read, so the settings already decoded stay in force. A fresh cold-reset assertion from the board does start a new read.

Top module: `boot_mode_loader`

## Requirements
- R1: While `pwr_ok` is low at a clock edge, the loader is cleared for the following cycle. In that cycle `mode_clk`, `cfg_done`, every decoded field and both core reset outputs are 0, and `mode_din` has no effect.
- R2: While `pwr_ok` is high, `mode_clk` repeats every `CLK_DIV` clocks and is high for `CLK_DIV/2` of them. It starts low after power-good or a restart, and it keeps running after the load completes.
- R3: Each rising edge of `mode_clk` during a load samples `mode_din` as the next stream bit, starting with bit 0. The load is `STREAM_BITS` bits long.
- R4: `cfg_done` rises on the same clock edge that samples bit `STREAM_BITS-1` and is 0 before that. The decoded outputs are 0 until `cfg_done` rises.
- R5: Stream bits 7:5 (bit 7 most significant) form a ratio code c. For c from 0 to 6, `cfg_ratio` = c+2. For c = 7, `cfg_ratio` = 0 and `cfg_reserved` = 1.
- R6: Bit 8 drives `cfg_big_endian`, bit 12 drives `cfg_bus32`, bits 17:15 (bit 17 most significant) drive `cfg_wr_delay`, and bit 19 drives `cfg_fastmul_off`. No other stream position changes any output.
- R7: `cfg_wr_mode` = {bit 10, bit 9}. The codes are 2'b00 for the compatible mode, 2'b10 for pipelined, 2'b11 for reissue and 2'b01 for reserved. The reserved code also sets `cfg_reserved`.
- R8: Once `cfg_done` is high, `cfg_done` and all decoded outputs stay constant until `pwr_ok` drops or `cold_rst_n` falls. Toggling `mode_din` in that time has no effect.
- R9: `core_cold_rst_n` is 0 during a load whatever `cold_rst_n` does. It rises one clock after both `cfg_done` and `cold_rst_n` are high.
- R10: `core_rst_n` is 0 whenever `core_cold_rst_n` is 0. It rises exactly `RST_EXTRA` clocks after `core_cold_rst_n` rises.
- R11: A low on `warm_rst_n` drives `core_rst_n` low on the next clock. `core_cold_rst_n`, `cfg_done` and the decoded fields are left unchanged. After release, `core_rst_n` is low for `RST_EXTRA` more clocks.
- R12: A high-to-low change on `cold_rst_n` while `pwr_ok` is high restarts the load. On the next cycle `cfg_done`, the fields and both core resets are 0, and the mode clock phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_ok | input | 1 | Power-good; low acts as the synchronous clear of the whole loader |
| cold_rst_n | input | 1 | Board cold reset, active low; a falling change restarts the load |
| warm_rst_n | input | 1 | Board warm reset, active low |
| mode_din | input | 1 | Serial mode stream data |
| mode_clk | output | 1 | Slow mode clock for the external stream source |
| cfg_done | output | 1 | Whole stream has been read and decoded |
| cfg_ratio | output | 4 | Pipeline-to-bus clock ratio, 2..8, 0 for the reserved code |
| cfg_big_endian | output | 1 | Big-endian byte order selected |
| cfg_bus32 | output | 1 | Narrow (32-bit) system bus selected |
| cfg_wr_mode | output | 2 | Non-block write mode code |
| cfg_wr_delay | output | 3 | Write address-to-data gap in bus cycles |
| cfg_fastmul_off | output | 1 | Fast multiply disabled |
| cfg_reserved | output | 1 | A reserved ratio or write-mode code was read |
| core_cold_rst_n | output | 1 | Cold reset released to the core, active low |
| core_rst_n | output | 1 | Warm reset released to the core, active low |

## Verification
The decoded fields and `cfg_done` change on the clock edge where the final rising edge of `mode_clk` occurs. The bench therefore waits for that edge of the mode clock and samples on the following falling clock edge. `core_cold_rst_n` is one register further back, so the bench checks it as still low in that sample and as high in the next one. `core_rst_n` is then counted low on falling clock edges until it rises, and the count must equal `RST_EXTRA`; the bench counts the same way after a warm-reset release. Restart and power-loss clears are registered once, so they are sampled on the first falling clock edge after the triggering input was set.

// File: rtl/bml_pkg.sv
// Shared definitions for the boot-mode loader.
// Assumes: the stream carries the settings at the fixed positions listed below;
// every other position is don't-care and is not stored.
package bml_pkg;

    // Stream positions that carry settings (behaviour-defined)
    localparam int RATIO_LSB = 5;
    localparam int BIG_POS   = 8;
    localparam int WRM_LSB   = 9;
    localparam int BUS_POS   = 12;
    localparam int DLY_LSB   = 15;
    localparam int FMUL_POS  = 19;

    // Number of stored stream bits and the highest stored position
    localparam int NKEEP   = 11;
    localparam int TOP_POS = FMUL_POS;

    typedef enum logic [1:0] {
        WRM_COMPAT  = 2'b00,
        WRM_RSVD    = 2'b01,
        WRM_PIPE    = 2'b10,
        WRM_REISSUE = 2'b11
    } wr_mode_e;

    typedef struct packed {
        logic [3:0] ratio;
        logic       big_endian;
        logic       bus32;
        wr_mode_e   wr_mode;
        logic [2:0] wr_delay;
        logic       fastmul_off;
        logic       reserved;
    } mode_cfg_t;

    // Stream position stored in slot j of the packed keep vector
    function automatic int keep_pos(input int j);
        int p;
        if (j < 3)       p = RATIO_LSB + j;
        else if (j == 3) p = BIG_POS;
        else if (j < 6)  p = WRM_LSB + (j - 4);
        else if (j == 6) p = BUS_POS;
        else if (j < 10) p = DLY_LSB + (j - 7);
        else             p = FMUL_POS;
        return p;
    endfunction

    // Turn the packed keep vector into decoded settings
    function automatic mode_cfg_t decode_keep(input logic [NKEEP-1:0] v);
        mode_cfg_t  c;
        logic [2:0] rc;
        logic [1:0] wm;
        rc            = v[2:0];
        wm            = v[5:4];
        c.ratio       = (rc == 3'd7) ? 4'd0 : ({1'b0, rc} + 4'd2);
        c.big_endian  = v[3];
        c.wr_mode     = wr_mode_e'(wm);
        c.bus32       = v[6];
        c.wr_delay    = v[9:7];
        c.fastmul_off = v[10];
        c.reserved    = (rc == 3'd7) || (wm == 2'b01);
        return c;
    endfunction

endpackage

// File: rtl/bml_clkdiv.sv
// Mode clock divider: free-running counter that divides clk by DIV.
// Gives a registered mode clock and a strobe on the cycle whose edge raises it.
// Assumes: DIV is even and at least 8, so data set after a rising edge has setup margin.
module bml_clkdiv #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic restart,
    output logic mode_clk,
    output logic sample_stb
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    // Next count: wraps at DIV-1, forced to zero by a restart
    always_comb begin
        if (restart)                     cnt_nxt = '0;
        else if (cnt_q == CW'(DIV - 1))  cnt_nxt = '0;
        else                             cnt_nxt = cnt_q + 1'b1;
    end

    // Counter and registered clock; high during the upper half of the count
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            cnt_q    <= '0;
            mode_clk <= 1'b0;
        end else begin
            cnt_q    <= cnt_nxt;
            mode_clk <= (cnt_nxt >= CW'(HALF));
        end
    end

    assign sample_stb = !restart && (cnt_q == CW'(HALF - 1));
endmodule

// File: rtl/bml_shift.sv
// Bit counter and capture: counts stream bits on each strobe and stores only
// the positions that carry settings. Flags the last bit and the finished load.
// Assumes: BITS is larger than the highest stored position.
module bml_shift
    import bml_pkg::*;
#(
    parameter int BITS = 256
) (
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             restart,
    input  logic             stb,
    input  logic             din,
    output logic [NKEEP-1:0] keep_nxt,
    output logic             last,
    output logic             done
);
    localparam int IW = $clog2(BITS);

    logic [IW-1:0]    idx_q;
    logic [NKEEP-1:0] keep_q;
    logic             take;

    assign take = stb && !done;
    assign last = take && (idx_q == IW'(BITS - 1));

    // Bit index and completion flag
    always_ff @(posedge clk) begin
        if (!pwr_ok || restart) begin
            idx_q <= '0;
            done  <= 1'b0;
        end else if (take) begin
            if (last) done  <= 1'b1;
            else      idx_q <= idx_q + 1'b1;
        end
    end

    // One capture slot per stored stream position
    for (genvar j = 0; j < NKEEP; j++) begin : g_keep
        localparam int POS = keep_pos(j);
        assign keep_nxt[j] = (take && idx_q == IW'(POS)) ? din : keep_q[j];
    end

    // Captured settings bits
    always_ff @(posedge clk) begin
        if (!pwr_ok || restart) keep_q <= '0;
        else                    keep_q <= keep_nxt;
    end
endmodule

// File: rtl/bml_decode.sv
// Field decode: registers the decoded settings on the edge that takes the last bit.
// Assumes: keep_in already includes any bit taken on that same edge.
module bml_decode
    import bml_pkg::*;
(
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             restart,
    input  logic             load,
    input  logic [NKEEP-1:0] keep_in,
    output mode_cfg_t        cfg
);
    // Hold decoded settings; cleared on power loss or restart
    always_ff @(posedge clk) begin
        if (!pwr_ok || restart) cfg <= mode_cfg_t'('0);
        else if (load)          cfg <= decode_keep(keep_in);
    end
endmodule

// File: rtl/bml_rstseq.sv
// Reset sequencer: releases the core cold reset once the load is done and the
// board cold reset is off, then the core warm reset EXTRA clocks later.
// Assumes: done drops on the edge that restarts a load.
module bml_rstseq #(
    parameter int EXTRA = 65
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic done,
    input  logic cold_rst_n,
    input  logic warm_rst_n,
    output logic core_cold_rst_n,
    output logic core_rst_n
);
    localparam int REL = EXTRA + 1;
    localparam int EW  = $clog2(REL + 1);

    logic [EW-1:0] ext_q;
    logic          cold_rel_q;
    logic          go;

    assign go = done && cold_rst_n && warm_rst_n;

    // Cold release flag and saturating warm-release counter
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            cold_rel_q <= 1'b0;
            ext_q      <= '0;
        end else begin
            cold_rel_q <= done && cold_rst_n;
            if (!go)                   ext_q <= '0;
            else if (ext_q != EW'(REL)) ext_q <= ext_q + 1'b1;
        end
    end

    assign core_cold_rst_n = cold_rel_q;
    assign core_rst_n      = (ext_q == EW'(REL));
endmodule

// File: rtl/boot_mode_loader.sv
// Top of the boot-mode loader: divider, capture, decode and reset sequencing.
// Assumes: pwr_ok is synchronous to clk and serves as the loader's active-low reset.
module boot_mode_loader
    import bml_pkg::*;
#(
    parameter int CLK_DIV     = 256,
    parameter int STREAM_BITS = 256,
    parameter int RST_EXTRA   = 65
) (
    input  logic       clk,
    input  logic       pwr_ok,
    input  logic       cold_rst_n,
    input  logic       warm_rst_n,
    input  logic       mode_din,
    output logic       mode_clk,
    output logic       cfg_done,
    output logic [3:0] cfg_ratio,
    output logic       cfg_big_endian,
    output logic       cfg_bus32,
    output logic [1:0] cfg_wr_mode,
    output logic [2:0] cfg_wr_delay,
    output logic       cfg_fastmul_off,
    output logic       cfg_reserved,
    output logic       core_cold_rst_n,
    output logic       core_rst_n
);
    logic             cold_q;
    logic             restart;
    logic             stb;
    logic             last;
    logic [NKEEP-1:0] keep_nxt;
    mode_cfg_t        cfg;

    // Previous board cold reset level, for detecting a new assertion
    always_ff @(posedge clk) begin
        if (!pwr_ok) cold_q <= 1'b0;
        else         cold_q <= cold_rst_n;
    end

    assign restart = cold_q && !cold_rst_n;

    bml_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .pwr_ok    (pwr_ok),
        .restart   (restart),
        .mode_clk  (mode_clk),
        .sample_stb(stb)
    );

    bml_shift #(.BITS(STREAM_BITS)) u_shift (
        .clk     (clk),
        .pwr_ok  (pwr_ok),
        .restart (restart),
        .stb     (stb),
        .din     (mode_din),
        .keep_nxt(keep_nxt),
        .last    (last),
        .done    (cfg_done)
    );

    bml_decode u_dec (
        .clk    (clk),
        .pwr_ok (pwr_ok),
        .restart(restart),
        .load   (last),
        .keep_in(keep_nxt),
        .cfg    (cfg)
    );

    bml_rstseq #(.EXTRA(RST_EXTRA)) u_rst (
        .clk            (clk),
        .pwr_ok         (pwr_ok),
        .done           (cfg_done),
        .cold_rst_n     (cold_rst_n),
        .warm_rst_n     (warm_rst_n),
        .core_cold_rst_n(core_cold_rst_n),
        .core_rst_n     (core_rst_n)
    );

    assign cfg_ratio       = cfg.ratio;
    assign cfg_big_endian  = cfg.big_endian;
    assign cfg_bus32       = cfg.bus32;
    assign cfg_wr_mode     = cfg.wr_mode;
    assign cfg_wr_delay    = cfg.wr_delay;
    assign cfg_fastmul_off = cfg.fastmul_off;
    assign cfg_reserved    = cfg.reserved;
endmodule

// File: rtl/bml_checker.sv
// Property checker for the boot-mode loader, attached through bind.
// Assumes: only the top-level ports are observed.
module bml_checker (
    input logic       clk,
    input logic       pwr_ok,
    input logic       cold_rst_n,
    input logic       warm_rst_n,
    input logic       mode_clk,
    input logic       cfg_done,
    input logic [3:0] cfg_ratio,
    input logic       cfg_big_endian,
    input logic       cfg_bus32,
    input logic [1:0] cfg_wr_mode,
    input logic [2:0] cfg_wr_delay,
    input logic       cfg_fastmul_off,
    input logic       cfg_reserved,
    input logic       core_cold_rst_n,
    input logic       core_rst_n
);
    AST_PWR_CLEAR: assert property (@(posedge clk)
        !pwr_ok |=> (!mode_clk && !cfg_done && cfg_ratio == 4'd0 && !core_cold_rst_n && !core_rst_n)); // R1

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!pwr_ok)
        cfg_done && cold_rst_n |=> cfg_done); // R8

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!pwr_ok)
        cfg_done && cold_rst_n |=> $stable({cfg_ratio, cfg_big_endian, cfg_bus32, cfg_wr_mode,
                                            cfg_wr_delay, cfg_fastmul_off, cfg_reserved})); // R8

    AST_COLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!pwr_ok)
        !cfg_done |-> !core_cold_rst_n); // R9

    AST_WARM_AFTER_COLD: assert property (@(posedge clk) disable iff (!pwr_ok)
        !core_cold_rst_n |-> !core_rst_n); // R10

    AST_WARM_PULL: assert property (@(posedge clk) disable iff (!pwr_ok)
        !warm_rst_n |=> !core_rst_n); // R11

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!pwr_ok)
        $past(cold_rst_n) && !cold_rst_n |=> (!cfg_done && !core_cold_rst_n && cfg_ratio == 4'd0)); // R12

    AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!pwr_ok)
        cfg_done |-> (cfg_ratio <= 4'd8 && cfg_ratio != 4'd1)); // R5

    AST_RATIO_RSVD: assert property (@(posedge clk) disable iff (!pwr_ok)
        cfg_done && cfg_ratio == 4'd0 |-> cfg_reserved); // R5

    AST_WRM_RSVD: assert property (@(posedge clk) disable iff (!pwr_ok)
        cfg_done && cfg_wr_mode == 2'b01 |-> cfg_reserved); // R7
endmodule

bind boot_mode_loader bml_checker u_chk (
    .clk            (clk),
    .pwr_ok         (pwr_ok),
    .cold_rst_n     (cold_rst_n),
    .warm_rst_n     (warm_rst_n),
    .mode_clk       (mode_clk),
    .cfg_done       (cfg_done),
    .cfg_ratio      (cfg_ratio),
    .cfg_big_endian (cfg_big_endian),
    .cfg_bus32      (cfg_bus32),
    .cfg_wr_mode    (cfg_wr_mode),
    .cfg_wr_delay   (cfg_wr_delay),
    .cfg_fastmul_off(cfg_fastmul_off),
    .cfg_reserved   (cfg_reserved),
    .core_cold_rst_n(core_cold_rst_n),
    .core_rst_n     (core_rst_n)
);

// File: tb/sim_boot_mode_loader.sv
// Bench for the boot-mode loader: sweeps 16 streams covering every ratio and
// write-mode code, both restart paths, warm reset and release timing.
module sim_boot_mode_loader;
    localparam int DIV   = 8;
    localparam int BITS  = 24;
    localparam int EXTRA = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       pwr_ok, cold_rst_n, warm_rst_n, mode_din;
    logic       mode_clk, cfg_done, cfg_big_endian, cfg_bus32, cfg_fastmul_off, cfg_reserved;
    logic [3:0] cfg_ratio;
    logic [1:0] cfg_wr_mode;
    logic [2:0] cfg_wr_delay;
    logic       core_cold_rst_n, core_rst_n;

    boot_mode_loader #(.CLK_DIV(DIV), .STREAM_BITS(BITS), .RST_EXTRA(EXTRA)) u0 (
        .clk(clk), .pwr_ok(pwr_ok), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .mode_din(mode_din), .mode_clk(mode_clk), .cfg_done(cfg_done), .cfg_ratio(cfg_ratio),
        .cfg_big_endian(cfg_big_endian), .cfg_bus32(cfg_bus32), .cfg_wr_mode(cfg_wr_mode),
        .cfg_wr_delay(cfg_wr_delay), .cfg_fastmul_off(cfg_fastmul_off),
        .cfg_reserved(cfg_reserved), .core_cold_rst_n(core_cold_rst_n), .core_rst_n(core_rst_n)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    task automatic chk_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stream for sweep step t: fields from t, filler bits elsewhere
    function automatic logic [BITS-1:0] make_stream(input int t);
        logic [BITS-1:0] s;
        s       = BITS'(t * 40503 + 12345);
        s[7:5]  = 3'(t % 8);
        s[8]    = 1'((t ^ (t >> 2)) & 1);
        s[10:9] = 2'(t % 4);
        s[12]   = 1'((t >> 1) & 1);
        s[17:15] = 3'((t * 3) % 8);
        s[19]   = 1'((t >> 3) & 1);
        return s;
    endfunction

    task automatic check_fields(input int t);
        int rc;
        rc = t % 8;
        chk_eq("R5 ratio", int'(cfg_ratio), (rc == 7) ? 0 : rc + 2);
        chk_eq("R7 reserved flag", int'(cfg_reserved), ((rc == 7) || (t % 4 == 1)) ? 1 : 0);
        chk_eq("R6 big endian", int'(cfg_big_endian), (t ^ (t >> 2)) & 1);
        chk_eq("R6 bus32", int'(cfg_bus32), (t >> 1) & 1);
        chk_eq("R7 write mode", int'(cfg_wr_mode), t % 4);
        chk_eq("R3 R6 write delay", int'(cfg_wr_delay), (t * 3) % 8);
        chk_eq("R6 fast multiply off", int'(cfg_fastmul_off), (t >> 3) & 1);
    endtask

    // Feed bits 1..BITS-1 after each mode clock rise; bit 0 is already on mode_din
    task automatic load_stream(input logic [BITS-1:0] s);
        for (int i = 1; i < BITS; i++) begin
            @(posedge mode_clk);
            @(negedge clk);
            mode_din = s[i];
            if (i == BITS - 1) begin
                chk_eq("R4 done before last bit", int'(cfg_done), 0);
                chk_eq("R9 cold held during load", int'(core_cold_rst_n), 0);
            end
        end
        @(posedge mode_clk);
        @(negedge clk);
        chk_eq("R3 R4 done at last bit", int'(cfg_done), 1);
    endtask

    // Wait for cold release, then count warm-reset low cycles
    task automatic count_release(input string req);
        int k;
        int n;
        k = 0;
        while (!core_cold_rst_n && k < 50) begin
            k++;
            @(negedge clk);
        end
        n = 0;
        while (!core_rst_n && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk_eq(req, n, EXTRA);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [BITS-1:0] s;
        int k;
        int hi;
        int lo;
        pwr_ok = 1'b0; cold_rst_n = 1'b0; warm_rst_n = 1'b1; mode_din = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mode_din = ~mode_din;
            chk_eq("R1 mode clock idle", int'(mode_clk), 0);
        end
        chk_eq("R1 done clear", int'(cfg_done), 0);
        chk_eq("R1 ratio clear", int'(cfg_ratio), 0);
        chk_eq("R1 core cold reset", int'(core_cold_rst_n), 0);
        chk_eq("R1 core warm reset", int'(core_rst_n), 0);

        // First load with board cold reset held past completion
        s = make_stream(0);
        mode_din = s[0];
        pwr_ok = 1'b1;
        load_stream(s);
        check_fields(0);
        repeat (3) @(negedge clk);
        chk_eq("R9 cold held by board", int'(core_cold_rst_n), 0);
        cold_rst_n = 1'b1;
        @(negedge clk);
        count_release("R10 release gap");

        // Mode clock shape after the load
        k = 0;
        while (mode_clk && k < 20) begin k++; @(negedge clk); end
        k = 0;
        while (!mode_clk && k < 20) begin k++; @(negedge clk); end
        hi = 0;
        while (mode_clk && hi < 40) begin hi++; @(negedge clk); end
        lo = 0;
        while (!mode_clk && lo < 40) begin lo++; @(negedge clk); end
        chk_eq("R2 high time", hi, DIV / 2);
        chk_eq("R2 period", hi + lo, DIV);

        // Warm reset keeps the settings
        warm_rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R11 warm pulls core reset", int'(core_rst_n), 0);
        chk_eq("R11 cold untouched", int'(core_cold_rst_n), 1);
        for (int i = 0; i < 2 * DIV; i++) begin
            mode_din = ~mode_din;
            @(negedge clk);
        end
        chk_eq("R11 no reload", int'(cfg_done), 1);
        check_fields(0);
        warm_rst_n = 1'b1;
        @(negedge clk);
        count_release("R11 warm release gap");

        // Sweep: odd steps restart by cold reset, even steps by power loss
        for (int t = 1; t < 16; t++) begin
            s = make_stream(t);
            if (t % 2 == 1) begin
                mode_din = s[0];
                cold_rst_n = 1'b0;
                @(negedge clk);
                chk_eq("R12 done cleared", int'(cfg_done), 0);
                chk_eq("R12 fields cleared", int'(cfg_ratio), 0);
                chk_eq("R12 core cold reset", int'(core_cold_rst_n), 0);
                chk_eq("R12 core warm reset", int'(core_rst_n), 0);
                cold_rst_n = 1'b1;
                load_stream(s);
                check_fields(t);
                chk_eq("R9 release lags done", int'(core_cold_rst_n), 0);
                @(negedge clk);
                chk_eq("R9 released", int'(core_cold_rst_n), 1);
                count_release("R10 release gap");
            end else begin
                pwr_ok = 1'b0;
                cold_rst_n = 1'b0;
                for (int i = 0; i < 3; i++) begin
                    mode_din = ~mode_din;
                    @(negedge clk);
                end
                chk_eq("R1 done cleared", int'(cfg_done), 0);
                chk_eq("R1 mode clock idle", int'(mode_clk), 0);
                chk_eq("R1 core warm reset", int'(core_rst_n), 0);
                mode_din = s[0];
                pwr_ok = 1'b1;
                load_stream(s);
                check_fields(t);
                cold_rst_n = 1'b1;
                @(negedge clk);
                count_release("R10 release gap");
            end
            // Data toggling after completion has no effect
            for (int i = 0; i < DIV; i++) begin
                mode_din = ~mode_din;
                @(negedge clk);
            end
            chk_eq("R8 done held", int'(cfg_done), 1);
            chk_eq("R8 ratio held", int'(cfg_ratio), (t % 8 == 7) ? 0 : (t % 8) + 2);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule